// File: doc/BRIEF.md
# SPI Command Decoder for Host Bus Control

This block is an SPI slave that a companion processor uses to steer a host-side bus state machine. The processor is the SPI master and may clock it at up to 50 MHz. Each transfer carries a two-byte command: an opcode and an argument. Some commands answer a bus cycle that the host has opened. These supply a read-data byte, an interrupt vector byte, or a write-acknowledge event, and each is passed to the bus cycle engine as a one-cycle strobe. Other commands act on side-band controls. They set or clear the interrupt request level toward the host, fire a non-maskable interrupt pulse, choose the video and audio source selects, and set the data-bus drive direction and high-impedance control.

The SPI pins are oversampled in the system clock domain. A synchroniser chain is followed by edge detection, so the system clock must run well above twice the SCLK rate. A command takes effect only when chip select rises after exactly sixteen sampled bits.

The reply channels have no back-pressure. Each strobe (`rd_valid`, `vec_valid`, `wack_valid`) lasts one system clock, and the bus engine must take it in that cycle. The byte on `rd_data` or `vec_data` stays constant until the next command of the same kind replaces it, so the engine may also read the held value later.

Top module: `spi_busctl_decoder`

## Requirements
- R1: After reset, `host_int_n`=1, `host_nmi_n`=1, `vid_sel`=0, `aud_sel`=0, `bus_drive`=0, `bus_hiz`=1, `rd_data`=0, `vec_data`=0, and all strobes are low.
- R2: SPI mode 0, MSB first. MOSI is sampled on each SCLK rising edge while `spi_cs_n` is low. The first 8 bits form the opcode and the next 8 bits form the argument.
- R3: When `spi_cs_n` rises after any bit count other than 16, including 15 and 17, the frame is discarded and no output changes.
- R4: Opcodes other than 0x01, 0x02, 0x03, 0x10, 0x20 and 0x30 change no output.
- R5: Opcode 0x01 loads the argument into `rd_data` and raises `rd_valid` for exactly one clock. `rd_data` holds its value otherwise.
- R6: Opcode 0x02 loads the argument into `vec_data` and raises `vec_valid` for exactly one clock. `vec_data` holds its value otherwise.
- R7: Opcode 0x03 raises `wack_valid` for exactly one clock.
- R8: Opcode 0x10 sets `host_int_n` to the inverse of argument bit 0. The level is held until the next 0x10 command and changes only within a few clocks after a chip-select rise.
- R9: Opcode 0x10 with argument bit 1 set drives `host_nmi_n` low for exactly 8 system clocks. A request that arrives while a pulse is running is ignored.
- R10: Opcode 0x20 sets `vid_sel` from argument bits [3:0] and `aud_sel` from argument bits [7:4].
- R11: Opcode 0x30 sets `bus_drive` from argument bit 0 and `bus_hiz` from argument bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock from the master |
| spi_mosi | input | 1 | SPI serial data from the master |
| spi_cs_n | input | 1 | SPI chip select, active low, frames a command |
| rd_valid | output | 1 | One-clock strobe: new read-data byte |
| rd_data | output | 8 | Read-data byte for the pending host read |
| vec_valid | output | 1 | One-clock strobe: new interrupt vector |
| vec_data | output | 8 | Interrupt vector byte for the acknowledge cycle |
| wack_valid | output | 1 | One-clock strobe: write cycle may complete |
| host_int_n | output | 1 | Maskable interrupt request to the host, active low |
| host_nmi_n | output | 1 | Non-maskable interrupt pulse to the host, active low |
| vid_sel | output | 4 | Video source multiplexer select |
| aud_sel | output | 4 | Audio source multiplexer select |
| bus_drive | output | 1 | Data-bus direction, 1 drives toward the host |
| bus_hiz | output | 1 | Data-bus high-impedance control, 1 releases the bus |

## Verification
A bit counter that has drifted shows at the ports as a frame that acts when it should be discarded, or as an ignored good frame. Such a fault is visible within about four clocks after the chip-select rise. A corrupted shift register shows up as wrong bits in the held reply bytes or in the select outputs after that same frame. A stuck or miscounted pulse counter shows as an NMI low time other than 8 clocks, or as a strobe wider than one clock. A faulty opcode decoder shows as the wrong output changing after a single command.

// File: rtl/spi_busctl_pkg.sv
package spi_busctl_pkg;
  localparam int OP_W    = 8;
  localparam int ARG_W   = 8;
  localparam int FRAME_W = OP_W + ARG_W;

  typedef enum logic [OP_W-1:0] {
    OP_RDATA  = 8'h01,
    OP_VECTOR = 8'h02,
    OP_WACK   = 8'h03,
    OP_IRQCTL = 8'h10,
    OP_MUXSEL = 8'h20,
    OP_BUSDIR = 8'h30
  } opcode_e;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [ARG_W-1:0] arg;
  } frame_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int             STAGES  = 2,
  parameter int             LANES   = 3,
  parameter logic [LANES-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] pin_i,
  output logic [LANES-1:0] lvl_o,
  output logic [LANES-1:0] rise_o
);
  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      logic [STAGES-1:0] chain;
      logic              last;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain <= {STAGES{RST_VAL[g]}};
          last  <= RST_VAL[g];
        end else begin
          chain <= {chain[STAGES-2:0], pin_i[g]};
          last  <= chain[STAGES-1];
        end
      end
      assign lvl_o[g]  = chain[STAGES-1];
      assign rise_o[g] = chain[STAGES-1] & ~last;
    end
  endgenerate
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_busctl_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sclk_rise,
  input  logic   mosi_lvl,
  input  logic   cs_n_lvl,
  input  logic   cs_rise,
  output logic   frame_valid,
  output frame_t frame
);
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam int CNT_SAT = FRAME_W + 1;

  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   bitcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      bitcnt <= '0;
    end else if (cs_n_lvl) begin
      bitcnt <= '0;
    end else if (sclk_rise) begin
      shreg <= {shreg[FRAME_W-2:0], mosi_lvl};
      if (bitcnt != CNT_W'(CNT_SAT)) bitcnt <= bitcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_valid <= 1'b0;
      frame       <= '0;
    end else begin
      frame_valid <= cs_rise && (bitcnt == CNT_W'(FRAME_W));
      if (cs_rise) frame <= frame_t'(shreg);
    end
  end
endmodule

// File: rtl/busctl_cmd_exec.sv
module busctl_cmd_exec
  import spi_busctl_pkg::*;
#(
  parameter int NMI_CLKS = 8,
  parameter int VID_W    = ARG_W / 2,
  parameter int AUD_W    = ARG_W - VID_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_valid,
  input  frame_t           frame,
  output logic             rd_valid,
  output logic [ARG_W-1:0] rd_data,
  output logic             vec_valid,
  output logic [ARG_W-1:0] vec_data,
  output logic             wack_valid,
  output logic             host_int_n,
  output logic             host_nmi_n,
  output logic [VID_W-1:0] vid_sel,
  output logic [AUD_W-1:0] aud_sel,
  output logic             bus_drive,
  output logic             bus_hiz
);
  localparam int NCNT_W = $clog2(NMI_CLKS + 1);

  logic [NCNT_W-1:0] nmi_cnt;
  logic              nmi_req;

  assign nmi_req    = frame_valid && (frame.op == OP_IRQCTL) && frame.arg[1];
  assign host_nmi_n = (nmi_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_cnt <= '0;
    end else if (nmi_cnt != '0) begin
      nmi_cnt <= nmi_cnt - 1'b1;
    end else if (nmi_req) begin
      nmi_cnt <= NCNT_W'(NMI_CLKS);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid   <= 1'b0;
      vec_valid  <= 1'b0;
      wack_valid <= 1'b0;
      rd_data    <= '0;
      vec_data   <= '0;
      host_int_n <= 1'b1;
      vid_sel    <= '0;
      aud_sel    <= '0;
      bus_drive  <= 1'b0;
      bus_hiz    <= 1'b1;
    end else begin
      rd_valid   <= 1'b0;
      vec_valid  <= 1'b0;
      wack_valid <= 1'b0;
      if (frame_valid) begin
        case (frame.op)
          OP_RDATA: begin
            rd_data  <= frame.arg;
            rd_valid <= 1'b1;
          end
          OP_VECTOR: begin
            vec_data  <= frame.arg;
            vec_valid <= 1'b1;
          end
          OP_WACK:   wack_valid <= 1'b1;
          OP_IRQCTL: host_int_n <= ~frame.arg[0];
          OP_MUXSEL: begin
            vid_sel <= frame.arg[VID_W-1:0];
            aud_sel <= frame.arg[ARG_W-1:VID_W];
          end
          OP_BUSDIR: begin
            bus_drive <= frame.arg[0];
            bus_hiz   <= frame.arg[1];
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_busctl_decoder.sv
module spi_busctl_decoder
  import spi_busctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NMI_CLKS    = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sclk,
  input  logic       spi_mosi,
  input  logic       spi_cs_n,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       vec_valid,
  output logic [7:0] vec_data,
  output logic       wack_valid,
  output logic       host_int_n,
  output logic       host_nmi_n,
  output logic [3:0] vid_sel,
  output logic [3:0] aud_sel,
  output logic       bus_drive,
  output logic       bus_hiz
);
  localparam int LANES    = 3;
  localparam int L_SCLK   = 0;
  localparam int L_MOSI   = 1;
  localparam int L_CS     = 2;

  logic [LANES-1:0] pins, lvl, rise;
  logic             frame_valid;
  frame_t           frame;

  assign pins = {spi_cs_n, spi_mosi, spi_sclk};

  spi_pin_sync #(
    .STAGES (SYNC_STAGES),
    .LANES  (LANES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (pins),
    .lvl_o (lvl),
    .rise_o(rise)
  );

  spi_frame_rx u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_rise  (rise[L_SCLK]),
    .mosi_lvl   (lvl[L_MOSI]),
    .cs_n_lvl   (lvl[L_CS]),
    .cs_rise    (rise[L_CS]),
    .frame_valid(frame_valid),
    .frame      (frame)
  );

  busctl_cmd_exec #(
    .NMI_CLKS(NMI_CLKS),
    .VID_W   (4),
    .AUD_W   (4)
  ) u_exec (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_valid(frame_valid),
    .frame      (frame),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .vec_valid  (vec_valid),
    .vec_data   (vec_data),
    .wack_valid (wack_valid),
    .host_int_n (host_int_n),
    .host_nmi_n (host_nmi_n),
    .vid_sel    (vid_sel),
    .aud_sel    (aud_sel),
    .bus_drive  (bus_drive),
    .bus_hiz    (bus_hiz)
  );
endmodule

// File: rtl/spi_busctl_decoder_chk.sv
module spi_busctl_decoder_chk #(
  parameter int NMI_CLKS = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_cs_n,
  input logic       rd_valid,
  input logic [7:0] rd_data,
  input logic       vec_valid,
  input logic [7:0] vec_data,
  input logic       wack_valid,
  input logic       host_int_n,
  input logic       host_nmi_n
);
  localparam int RUN_W = $clog2(NMI_CLKS + 2) + 1;

  logic [RUN_W-1:0] nmi_low_run;
  logic [3:0]       cs_low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_low_run <= '0;
      cs_low_run  <= '0;
    end else begin
      if (!host_nmi_n) nmi_low_run <= nmi_low_run + 1'b1;
      else             nmi_low_run <= '0;
      if (spi_cs_n)                cs_low_run <= '0;
      else if (cs_low_run != 4'hF) cs_low_run <= cs_low_run + 1'b1;
    end
  end

  a_r5_rd_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  a_r5_rd_held: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable(rd_data));
  a_r6_vec_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);
  a_r6_vec_held: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid |-> $stable(vec_data));
  a_r7_wack_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    wack_valid |=> !wack_valid);
  a_r4_one_reply_kind: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_valid, vec_valid, wack_valid}));
  a_r9_nmi_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_nmi_n) |-> (nmi_low_run == RUN_W'(NMI_CLKS)));
  a_r9_nmi_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    !host_nmi_n |-> (nmi_low_run < RUN_W'(NMI_CLKS)));
  a_r8_int_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(host_int_n) |-> (cs_low_run < 4'd5));
endmodule

bind spi_busctl_decoder spi_busctl_decoder_chk #(.NMI_CLKS(NMI_CLKS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .spi_cs_n  (spi_cs_n),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .vec_valid (vec_valid),
  .vec_data  (vec_data),
  .wack_valid(wack_valid),
  .host_int_n(host_int_n),
  .host_nmi_n(host_nmi_n)
);

// File: tb/spi_busctl_decoder_tb_top.sv
`timescale 1ns/1ps
module spi_busctl_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sclk = 1'b0, spi_mosi = 1'b0, spi_cs_n = 1'b1;
  logic rd_valid, vec_valid, wack_valid, host_int_n, host_nmi_n, bus_drive, bus_hiz;
  logic [7:0] rd_data, vec_data;
  logic [3:0] vid_sel, aud_sel;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  spi_busctl_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n),
    .rd_valid(rd_valid), .rd_data(rd_data), .vec_valid(vec_valid), .vec_data(vec_data),
    .wack_valid(wack_valid), .host_int_n(host_int_n), .host_nmi_n(host_nmi_n),
    .vid_sel(vid_sel), .aud_sel(aud_sel), .bus_drive(bus_drive), .bus_hiz(bus_hiz)
  );

  // port monitors, sampled on the falling edge
  int n_rd = 0, n_vec = 0, n_wack = 0, n_nmi = 0;
  int run_rd = 0, run_vec = 0, run_wack = 0, max_strobe = 0;
  int nmi_run = 0, nmi_last = 0;
  logic nmi_prev = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_valid)   begin n_rd++;   run_rd++;   end else run_rd = 0;
      if (vec_valid)  begin n_vec++;  run_vec++;  end else run_vec = 0;
      if (wack_valid) begin n_wack++; run_wack++; end else run_wack = 0;
      if (run_rd > max_strobe)   max_strobe = run_rd;
      if (run_vec > max_strobe)  max_strobe = run_vec;
      if (run_wack > max_strobe) max_strobe = run_wack;
      if (!host_nmi_n) nmi_run++;
      if (nmi_prev && !host_nmi_n) n_nmi++;
      if (!nmi_prev && host_nmi_n) begin nmi_last = nmi_run; nmi_run = 0; end
      nmi_prev = host_nmi_n;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // sends the first nbits of word MSB first, then extra trailing zero bits
  task automatic spi_send(input int nbits, input logic [15:0] word);
    spi_cs_n = 1'b0;
    wclk(4);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = (i < 16) ? word[15-i] : 1'b0;
      wclk(4);
      spi_sclk = 1'b1;
      wclk(4);
      spi_sclk = 1'b0;
    end
    wclk(4);
    spi_cs_n = 1'b1;
    wclk(16);
  endtask

  // [51:47] bits, [46:39] op, [38:31] arg,
  // [30:20] {int_n, drive, hiz, aud[3:0], vid[3:0]},
  // [19:16] pulse deltas {rd, vec, wack, nmi}, [15:8] rd_data, [7:0] vec_data
  localparam int NV = 13;
  localparam logic [51:0] VECS [NV] = '{
    {5'd16, 8'h01, 8'hA5, 11'b101_0000_0000, 4'b1000, 8'hA5, 8'h00}, // R5 R2
    {5'd16, 8'h02, 8'h38, 11'b101_0000_0000, 4'b0100, 8'hA5, 8'h38}, // R6
    {5'd16, 8'h03, 8'h00, 11'b101_0000_0000, 4'b0010, 8'hA5, 8'h38}, // R7
    {5'd16, 8'h10, 8'h01, 11'b001_0000_0000, 4'b0000, 8'hA5, 8'h38}, // R8 set
    {5'd16, 8'h10, 8'h02, 11'b101_0000_0000, 4'b0001, 8'hA5, 8'h38}, // R9, R8 clear
    {5'd16, 8'h20, 8'h5C, 11'b101_0101_1100, 4'b0000, 8'hA5, 8'h38}, // R10
    {5'd16, 8'h30, 8'h01, 11'b110_0101_1100, 4'b0000, 8'hA5, 8'h38}, // R11
    {5'd15, 8'h01, 8'h77, 11'b110_0101_1100, 4'b0000, 8'hA5, 8'h38}, // R3 short
    {5'd17, 8'h02, 8'h11, 11'b110_0101_1100, 4'b0000, 8'hA5, 8'h38}, // R3 long
    {5'd16, 8'h7E, 8'hFF, 11'b110_0101_1100, 4'b0000, 8'hA5, 8'h38}, // R4
    {5'd16, 8'h10, 8'h03, 11'b010_0101_1100, 4'b0001, 8'hA5, 8'h38}, // R8 R9
    {5'd16, 8'h01, 8'h3C, 11'b010_0101_1100, 4'b1000, 8'h3C, 8'h38}, // R5
    {5'd16, 8'h30, 8'h02, 11'b001_0101_1100, 4'b0000, 8'h3C, 8'h38}  // R11
  };

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int b_rd, b_vec, b_wack, b_nmi;
    logic [10:0] ctl;
    wclk(3);
    // R1: reset values
    chk({host_int_n, bus_drive, bus_hiz, aud_sel, vid_sel} == 11'b101_0000_0000,
        "R1 controls in reset", {host_int_n, bus_drive, bus_hiz, aud_sel, vid_sel}, 11'b101_0000_0000);
    rst_n = 1'b1;
    wclk(4);
    chk({rd_valid, vec_valid, wack_valid, host_nmi_n} == 4'b0001, "R1 strobes idle",
        {rd_valid, vec_valid, wack_valid, host_nmi_n}, 4'b0001);
    chk({rd_data, vec_data} == 16'h0000, "R1 reply bytes", {rd_data, vec_data}, 16'h0000);

    for (int v = 0; v < NV; v++) begin
      b_rd = n_rd; b_vec = n_vec; b_wack = n_wack; b_nmi = n_nmi;
      spi_send(int'(VECS[v][51:47]), VECS[v][46:31]);
      ctl = {host_int_n, bus_drive, bus_hiz, aud_sel, vid_sel};
      chk(ctl == VECS[v][30:20], $sformatf("R8/R10/R11 ctl vec%0d", v), ctl, VECS[v][30:20]);
      chk(n_rd - b_rd == int'(VECS[v][19]), $sformatf("R5 rd strobes vec%0d", v), n_rd - b_rd, VECS[v][19]);
      chk(n_vec - b_vec == int'(VECS[v][18]), $sformatf("R6 vec strobes vec%0d", v), n_vec - b_vec, VECS[v][18]);
      chk(n_wack - b_wack == int'(VECS[v][17]), $sformatf("R7 wack strobes vec%0d", v), n_wack - b_wack, VECS[v][17]);
      chk(n_nmi - b_nmi == int'(VECS[v][16]), $sformatf("R9 nmi pulses vec%0d", v), n_nmi - b_nmi, VECS[v][16]);
      chk(rd_data == VECS[v][15:8], $sformatf("R5 R3 R4 rd_data vec%0d", v), rd_data, VECS[v][15:8]);
      chk(vec_data == VECS[v][7:0], $sformatf("R6 R3 R4 vec_data vec%0d", v), vec_data, VECS[v][7:0]);
    end

    // directed corner checks
    chk(max_strobe == 1, "R5 R6 R7 strobe width", max_strobe, 1);
    chk(nmi_last == 8, "R9 nmi low width", nmi_last, 8);
    chk(host_nmi_n == 1'b1, "R9 nmi released", host_nmi_n, 1);

    // R3: chip select rising after only 8 bits carries nothing
    b_rd = n_rd;
    spi_send(8, 16'h0199);
    chk(n_rd == b_rd && rd_data == 8'h3C, "R3 eight-bit frame", rd_data, 8'h3C);

    // R1: reset from a non-default state
    rst_n = 1'b0;
    wclk(2);
    chk({host_int_n, bus_drive, bus_hiz, aud_sel, vid_sel, rd_data, vec_data} == 27'b101_0000_0000_00000000_00000000,
        "R1 reset restores", {host_int_n, bus_hiz, rd_data}, {1'b1, 1'b1, 8'h00});
    rst_n = 1'b1;
    wclk(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule